// File: doc/BRIEF.md
# Burst Address Sequencer (Linear or Interleaved, Four-Beat Wrap)

This block supplies the access address for a synchronous memory that supports four-beat bursts. On a cycle that opens a new access, the address presented at the input is captured as the burst start. On each later continue cycle, the two least significant address bits step to the next burst position. The bits above them stay at the captured value.

The step order is set by a static mode input. Linear order counts the low two bits upward from the start value modulo 4. Interleaved order XORs the start value with a beat count that runs 0, 1, 2, 3. In both orders the sequence comes back to the start address after four addresses.

An active-low clock enable freezes all state. A deselect cycle ends the burst, and any continue cycles that follow it leave the address unchanged until a new load.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `addr_out` reads 0 and no burst is open. A continue cycle before the first load leaves `addr_out` at 0.
- R2: An enabled edge (`cke_n`=0) with `adv`=0 and `cmd_valid`=1 loads `addr_in` as the burst start. `addr_out` equals that `addr_in` from this edge on.
- R3: With `ilv_order`=0, each enabled edge with `adv`=1 in an open burst sets `addr_out[1:0]` to its previous value plus 1, modulo 4.
- R4: With `ilv_order`=1, each continue edge sets `addr_out[1:0]` to start[1:0] XOR k. Here k is the count of continue edges since the load, modulo 4.
- R5: After four continue edges, `addr_out` is equal to the loaded start address again.
- R6: On a continue edge, `addr_out[ADDR_W-1:2]` keeps the value it had before the edge. `addr_in` is ignored on that edge.
- R7: An edge with `cke_n`=1 changes nothing. This holds for both load and continue inputs, and `addr_out` keeps its value.
- R8: An enabled edge with `adv`=0 and `cmd_valid`=0 is a deselect. It closes the burst without changing `addr_out`. Later continue edges hold `addr_out`, whatever `cmd_valid` is, until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; when high, the edge is ignored |
| cmd_valid | input | 1 | High when a new access is qualified (device selected) on a load cycle |
| adv | input | 1 | 0 = load the start address or deselect, 1 = continue the burst |
| ilv_order | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Address of the current access |

## Verification
Every result is due one edge after its stimulus. `addr_out` is decoded without further registers from the state captured at that edge, so a load or step is visible right after the edge that takes it. The bench drives each vector on a falling edge, lets one rising edge pass, and compares `addr_out` on the following falling edge. The inputs for the next vector are applied only after that comparison. Hold and deselect vectors compare against the value left by the vector before them, which shows that the ignored inputs had no effect at the port.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              cmd_valid,
  input  logic              adv,
  input  logic              ilv_order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic              open_q;

  wire do_load  = !cke_n && !adv && cmd_valid;
  wire do_desel = !cke_n && !adv && !cmd_valid;
  wire do_step  = !cke_n && adv && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      open_q  <= 1'b0;
    end else if (do_load) begin
      start_q <= addr_in;
      beat_q  <= '0;
      open_q  <= 1'b1;
    end else if (do_desel) begin
      open_q  <= 1'b0;
    end else if (do_step) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  wire [BEAT_W-1:0] lin_low = start_q[BEAT_W-1:0] + beat_q;
  wire [BEAT_W-1:0] ilv_low = start_q[BEAT_W-1:0] ^ beat_q;

  assign addr_out = {start_q[ADDR_W-1:BEAT_W], ilv_order ? ilv_low : lin_low};

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> addr_out == '0 || !rst_n); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> addr_out == $past(addr_in)); // R2

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !ilv_order) |=> (ilv_order || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R3

  AST_ILV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && ilv_order) |=> (!ilv_order || addr_out[0] != $past(addr_out[0]))); // R4

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R6

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(addr_out) || !$stable(ilv_order))); // R7

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && !open_q) |=> ($stable(addr_out) || !$stable(ilv_order))); // R8

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

  localparam int AW = 20;
  localparam int NV = 24;
  localparam int EW = 4 + 4 + AW + AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          adv = 1'b0;
  logic          ilv_order = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cmd_valid(cmd_valid),
    .adv(adv), .ilv_order(ilv_order), .addr_in(addr_in), .addr_out(addr_out)
  );

  // fields: req number, {cke_n, cmd_valid, adv, ilv_order}, addr_in, expected addr_out
  localparam logic [EW-1:0] VEC [NV] = '{
    {4'd2, 4'b0100, 20'h12346, 20'h12346},  // R2 linear load, low bits 2
    {4'd3, 4'b0010, 20'hABCDE, 20'h12347},  // R3 R6 addr_in ignored
    {4'd3, 4'b0010, 20'h00000, 20'h12344},  // R3 wraps low bits
    {4'd3, 4'b0010, 20'h00000, 20'h12345},  // R3
    {4'd5, 4'b0010, 20'h00000, 20'h12346},  // R5 back to start
    {4'd7, 4'b1010, 20'h00000, 20'h12346},  // R7 continue frozen
    {4'd7, 4'b1100, 20'h55555, 20'h12346},  // R7 load frozen
    {4'd7, 4'b0010, 20'h00000, 20'h12347},  // R7 resumes where it was
    {4'd2, 4'b0101, 20'hF00F1, 20'hF00F1},  // R2 interleaved load, low bits 1
    {4'd4, 4'b0011, 20'h00000, 20'hF00F0},  // R4 1^1
    {4'd4, 4'b0011, 20'h00000, 20'hF00F3},  // R4 1^2
    {4'd4, 4'b0011, 20'h00000, 20'hF00F2},  // R4 1^3
    {4'd5, 4'b0011, 20'h00000, 20'hF00F1},  // R5 wrap
    {4'd8, 4'b0001, 20'h77777, 20'hF00F1},  // R8 deselect
    {4'd8, 4'b0011, 20'h00000, 20'hF00F1},  // R8 continue held
    {4'd8, 4'b0111, 20'h00000, 20'hF00F1},  // R8 held with cmd_valid high
    {4'd2, 4'b0101, 20'h00003, 20'h00003},  // R2
    {4'd4, 4'b0011, 20'h00000, 20'h00002},  // R4 3^1
    {4'd4, 4'b0011, 20'h00000, 20'h00001},  // R4 3^2
    {4'd4, 4'b0011, 20'h00000, 20'h00000},  // R4 3^3
    {4'd5, 4'b0011, 20'h00000, 20'h00003},  // R5
    {4'd2, 4'b0100, 20'hA0003, 20'hA0003},  // R2 linear from 3
    {4'd6, 4'b0010, 20'h0FFFF, 20'hA0000},  // R6 no carry into upper bits
    {4'd3, 4'b0010, 20'h00000, 20'hA0001}   // R3
  };

  task automatic check(input int req, input logic [AW-1:0] exp);
    n_cmp++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL R%0d: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ctl, input logic [AW-1:0] a);
    {cke_n, cmd_valid, adv, ilv_order} = ctl;
    addr_in = a;
  endtask

  initial begin
    @(negedge clk);
    check(1, '0);  // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    apply(4'b0010, 20'h33333);
    @(negedge clk);
    check(1, '0);  // R1 continue before any load holds zero

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][2*AW+3:2*AW], VEC[i][2*AW-1:AW]);
      @(negedge clk);
      check(int'(VEC[i][EW-1:EW-4]), VEC[i][AW-1:0]);
    end

    // R7 long freeze mid-burst
    apply(4'b0010, '0);
    for (int k = 0; k < 5; k++) begin
      cke_n = 1'b1;
      @(negedge clk);
      check(7, 20'hA0001);
    end
    cke_n = 1'b0;
    @(negedge clk);
    check(3, 20'hA0002);  // R3 step after freeze

    // R1 reset mid-burst closes it
    rst_n = 1'b0;
    @(negedge clk);
    check(1, '0);
    rst_n = 1'b1;
    apply(4'b0011, '0);
    @(negedge clk);
    check(1, '0);  // R1 no burst open after reset

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule